// File: doc/BRIEF.md
# Square-root carry-select adder

A purely combinational adder that sums two N-bit operands and a carry-in and returns an N-bit sum and a carry-out. The operand width is cut into segments that widen by one bit each step going up from the least significant end. The default partition is 2, 3, 4, 5 and a trailing 2-bit segment, which together give 16 bits. The lowest segment receives the external carry directly, so it is a single generate/propagate ripple. Each higher segment ripples twice in parallel: once as if its incoming carry were 0 and once as if it were 1.

When the true carry reaches a segment boundary, a 2:1 selector picks that segment's sum bits and carry-out. The only serial path between segments is this chain of selectors. Because the segments widen, a wider segment gets more time to finish its two ripples before its select carry arrives. The segment widths are set by a packed parameter, with 8 bits per segment and segment 0 in the lowest byte. Their sum must equal the operand width.

Top module: `sqcsa_adder`

## Requirements
- R1: For any operands and carry-in, `{cout_o, sum_o}` equals the (N+1)-bit arithmetic sum `a_i + b_i + cin_i`.
- R2: With the default partition, segments cover bits 0-1, 2-4, 5-8, 9-13 and 14-15. A carry raised just below each boundary at bits 2, 5, 9 and 14 reaches the bit above that boundary.
- R3: When `b_i` is the bitwise inverse of `a_i`, every bit propagates. The result is then all zeros with carry-out 1 for carry-in 1, and all ones with carry-out 0 for carry-in 0.
- R4: All-ones plus one with carry-in 0 gives sum 0 and carry-out 1. All-ones plus all-ones with carry-in 1 gives all ones and carry-out 1.
- R5: In every segment above the lowest, the carry-1 candidate, taken as a (width+1)-bit value including its carry, equals the carry-0 candidate plus one.
- R6: The carry entering each segment equals the arithmetic carry into that segment's lowest bit from the lower bits of the operands and `cin_i`. The same operands with carry-in 1 give a result exactly one above the result with carry-in 0.
- R7: Zero plus zero with carry-in 0 gives sum 0 and carry-out 0.
- R8: The adder holds no state. Operands that change on every cycle give a result that depends only on the inputs currently applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
Every result settles in the same cycle its operands are applied, so the latency is zero clock cycles. The bench drives a new operand set at each rising edge and pushes the behavioural expectation into a queue. A monitor pops and compares it at the following falling edge, half a period after the inputs change, so the whole selector chain has settled. No result is ever compared against inputs from another cycle.

// File: rtl/sqcsa_pkg.sv
package sqcsa_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;
endpackage

// File: rtl/sqcsa_ripple.sv
module sqcsa_ripple
  import sqcsa_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  gp_t  [W-1:0] gp;
  logic [W:0]   c;

  always_comb begin
    c[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      gp[i].g  = a_i[i] & b_i[i];
      gp[i].p  = a_i[i] ^ b_i[i];
      c[i+1]   = gp[i].g | (gp[i].p & c[i]);
      sum_o[i] = gp[i].p ^ c[i];
    end
  end

  assign cout_o = c[W];
endmodule

// File: rtl/sqcsa_sel_blk.sv
module sqcsa_sel_blk #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic [W-1:0] c0_sum_o,
  output logic [W-1:0] c1_sum_o,
  output logic         c0_co_o,
  output logic         c1_co_o
);
  // both candidates evaluate while the select carry is still in flight
  sqcsa_ripple #(.W(W)) u_rip0 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(c0_sum_o), .cout_o(c0_co_o)
  );
  sqcsa_ripple #(.W(W)) u_rip1 (
    .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(c1_sum_o), .cout_o(c1_co_o)
  );

  assign sum_o  = sel_i ? c1_sum_o : c0_sum_o;
  assign cout_o = sel_i ? c1_co_o  : c0_co_o;
endmodule

// File: rtl/sqcsa_adder.sv
module sqcsa_adder #(
  parameter int              N     = 16,
  parameter int              NB    = 5,
  parameter logic [NB*8-1:0] BLK_W = {8'd2, 8'd5, 8'd4, 8'd3, 8'd2}
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  function automatic int blk_lo(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += int'(BLK_W[j*8 +: 8]);
    return s;
  endfunction

  logic [NB:0]   blk_c;
  logic [N-1:0]  cand0_sum, cand1_sum;
  logic [NB-1:0] cand0_co, cand1_co;

  assign blk_c[0] = cin_i;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    localparam int LO = blk_lo(k);
    localparam int W  = int'(BLK_W[k*8 +: 8]);
    if (k == 0) begin : g_base
      // carry-in known up front: no duplicate path needed
      sqcsa_ripple #(.W(W)) u_rip (
        .a_i   (a_i[LO +: W]),
        .b_i   (b_i[LO +: W]),
        .cin_i (blk_c[k]),
        .sum_o (sum_o[LO +: W]),
        .cout_o(blk_c[k+1])
      );
      assign cand0_sum[LO +: W] = sum_o[LO +: W];
      assign cand1_sum[LO +: W] = sum_o[LO +: W];
      assign cand0_co[k]        = blk_c[k+1];
      assign cand1_co[k]        = blk_c[k+1];
    end else begin : g_sel
      sqcsa_sel_blk #(.W(W)) u_sel (
        .a_i     (a_i[LO +: W]),
        .b_i     (b_i[LO +: W]),
        .sel_i   (blk_c[k]),
        .sum_o   (sum_o[LO +: W]),
        .cout_o  (blk_c[k+1]),
        .c0_sum_o(cand0_sum[LO +: W]),
        .c1_sum_o(cand1_sum[LO +: W]),
        .c0_co_o (cand0_co[k]),
        .c1_co_o (cand1_co[k])
      );
    end
  end

  assign cout_o = blk_c[NB];
endmodule

// File: rtl/sqcsa_adder_chk.sv
module sqcsa_adder_chk #(
  parameter int              N     = 16,
  parameter int              NB    = 5,
  parameter logic [NB*8-1:0] BLK_W = {8'd2, 8'd5, 8'd4, 8'd3, 8'd2}
) (
  input logic [N-1:0]  a_i,
  input logic [N-1:0]  b_i,
  input logic          cin_i,
  input logic [N-1:0]  sum_o,
  input logic          cout_o,
  input logic [NB:0]   blk_c,
  input logic [N-1:0]  cand0_sum,
  input logic [N-1:0]  cand1_sum,
  input logic [NB-1:0] cand0_co,
  input logic [NB-1:0] cand1_co
);
  function automatic int blk_lo(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += int'(BLK_W[j*8 +: 8]);
    return s;
  endfunction

  always_comb begin
    // R1
    total_sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (N+1)'(cin_i)))
      else $error("sum mismatch");
  end

  for (genvar k = 1; k <= NB; k++) begin : g_bnd
    localparam int             LO   = blk_lo(k);
    localparam logic [N:0]     MASK = {(N+1){1'b1}} >> (N + 1 - LO);
    logic [N:0] low_sum;
    always_comb begin
      low_sum = ({1'b0, a_i} & MASK) + ({1'b0, b_i} & MASK) + (N+1)'(cin_i);
      // R6
      seg_carry_chk: assert (blk_c[k] == low_sum[LO])
        else $error("segment carry %0d wrong", k);
    end
  end

  for (genvar k = 1; k < NB; k++) begin : g_cand
    localparam int LO = blk_lo(k);
    localparam int W  = int'(BLK_W[k*8 +: 8]);
    always_comb begin
      // R5
      cand_step_chk: assert ({cand1_co[k], cand1_sum[LO +: W]} ==
                             ({cand0_co[k], cand0_sum[LO +: W]} + (W+1)'(1)))
        else $error("candidate pair %0d inconsistent", k);
      // R5
      cand_mono_chk: assert (!cand0_co[k] || cand1_co[k])
        else $error("candidate carry order %0d", k);
    end
  end
endmodule

bind sqcsa_adder sqcsa_adder_chk #(.N(N), .NB(NB), .BLK_W(BLK_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o),
  .blk_c(blk_c), .cand0_sum(cand0_sum), .cand1_sum(cand1_sum),
  .cand0_co(cand0_co), .cand1_co(cand1_co)
);

// File: tb/sqcsa_adder_bench.sv
module sqcsa_adder_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a_r = '0, b_r = '0;
  logic cin_r = 1'b0;
  logic [N-1:0] sum_w;
  logic cout_w;

  int n_chk = 0;
  int n_bad = 0;
  logic [N:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sqcsa_adder u_sqcsa_adder (
    .a_i(a_r), .b_i(b_r), .cin_i(cin_r), .sum_o(sum_w), .cout_o(cout_w)
  );

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic cin, input string tag);
    @(posedge clk);
    a_r   <= a;
    b_r   <= b;
    cin_r <= cin;
    exp_q.push_back({1'b0, a} + {1'b0, b} + (N+1)'(cin));
    tag_q.push_back(tag);
  endtask

  // monitor: result is combinational, due half a period after drive
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      logic [N:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({cout_w, sum_w} !== e) begin
        n_bad++;
        $display("FAIL %s got=%h exp=%h", t, {cout_w, sum_w}, e);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [N-1:0] corner [8];
    logic [N-1:0] ra;
    corner = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
               16'h7FFF, 16'h5555, 16'hAAAA, 16'h3FFE};

    // R7: reset-time state with zero operands
    repeat (2) @(negedge clk);
    n_chk++;
    if ({cout_w, sum_w} !== '0) begin
      n_bad++;
      $display("FAIL R7 got=%h exp=%h", {cout_w, sum_w}, 17'h0);
    end
    @(posedge clk);
    rst_ni <= 1'b1;

    drive('0, '0, 1'b0, "R7");
    // R4
    drive('1, 16'h0001, 1'b0, "R4");
    drive('1, '1, 1'b1, "R4");
    // R2: carry raised just below each segment boundary
    drive(16'h0003, 16'h0001, 1'b0, "R2");
    drive(16'h001F, 16'h0001, 1'b0, "R2");
    drive(16'h01FF, 16'h0001, 1'b0, "R2");
    drive(16'h3FFF, 16'h0001, 1'b0, "R2");
    drive(16'h0002, 16'h0001, 1'b1, "R2");
    drive(16'h2000, 16'h2000, 1'b0, "R2");
    // R3: full propagate chains
    for (int i = 0; i < 20; i++) begin
      ra = N'($urandom);
      drive(ra, ~ra, 1'b1, "R3");
      drive(ra, ~ra, 1'b0, "R3");
    end
    // R6: identical operands, both carry-in values
    for (int i = 0; i < 100; i++) begin
      logic [N-1:0] x, y;
      x = N'($urandom);
      y = N'($urandom);
      drive(x, y, 1'b0, "R6");
      drive(x, y, 1'b1, "R6");
    end
    // R1: corner pairs in every combination
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int c = 0; c < 2; c++)
          drive(corner[i], corner[j], c[0], "R1");
    // R8: operands flipping every cycle
    for (int i = 0; i < 64; i++)
      drive(i[0] ? 16'hAAAA : 16'h5555, i[1] ? 16'hFFFF : 16'h0001, i[2], "R8");
    // R1: random
    for (int i = 0; i < 2000; i++)
      drive(N'($urandom), N'($urandom), 1'($urandom), "R1");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule